// File: doc/BRIEF.md
# Program Counter Sequencer with Branch Resolution

This block keeps the program counter of a single-cycle processor and picks its next value on every clock edge. The decoder supplies a set of control flags: a branch enable, a branch-kind code, a jump flag and a jump-register flag. The datapath supplies the two register operands, the 16-bit immediate and the 26-bit jump target field. The block decides on its own whether a conditional branch is taken. Comparisons against zero and between the operands use two's-complement signed values.

The block presents the current PC and the value PC+4. The register file uses PC+4 as the return address for jump-and-link. Instruction fetch, the register file and the ALU sit outside the block. The PC changes only on a rising clock edge. A synchronous active-high reset returns it to address zero.

Top module: `pc_sequencer`

## Requirements
- R1: With `rst` high at a rising edge, `pc` becomes 0 after that edge and `pc_plus4` reads 4.
- R2: When `br_en`, `jmp` and `jreg` are all low, `pc` advances by 4 at each rising edge.
- R3: `pc_plus4` always equals `pc` + 4, modulo 2^32. This is the link value.
- R4: A taken branch loads `pc`+4 plus the sign-extended immediate shifted left by two. Negative immediates branch backwards.
- R5: Branch kind code 0 (equal) is taken when `rs_val` equals `rt_val`.
- R6: Branch kind code 1 (not equal) is taken when `rs_val` differs from `rt_val`.
- R7: Branch kind code 2 (less than) is taken when `rs_val` < `rt_val`, with both operands read as signed.
- R8: Branch kind code 3 (nonzero) is taken when `rs_val` is not zero.
- R9: Branch kind code 4 (non-negative) is taken when `rs_val`, read as signed, is zero or greater.
- R10: A branch is taken only when `br_en` is high and the selected condition holds. Kind codes 5 to 7 are never taken. A branch that is not taken advances `pc` by 4.
- R11: With `jmp` high, `pc` loads the upper four bits of the current `pc`, then `jtarget`, then two zero bits.
- R12: With `jreg` high, `pc` loads `rs_val`.
- R13: Priority runs from `jreg`, to `jmp`, to a taken branch, to `pc`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_en | input | 1 | Current instruction is a conditional branch |
| br_kind | input | 3 | Branch condition code (0 eq, 1 ne, 2 lt, 3 nez, 4 gez) |
| jmp | input | 1 | Pseudo-direct jump (also used for jump-and-link) |
| jreg | input | 1 | Register-indirect jump |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm | input | 16 | Branch offset in instruction words |
| jtarget | input | 26 | Jump target word address |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current PC plus 4, used as the link value |

## Verification
The control and operand inputs are combinational. The new `pc` is therefore due after the single register stage, one rising edge after the inputs are applied, and `pc_plus4` follows in the same cycle. The bench drives each instruction's inputs one time unit after a rising edge. It then waits for the next rising edge and samples both outputs one time unit later, clear of the edge. Reset works the same way: the check comes one edge after `rst` is sampled high. Each scenario task tracks the expected PC in the bench, so the checks that follow start from a known value.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    typedef enum logic [2:0] {
        BK_EQ  = 3'd0,
        BK_NE  = 3'd1,
        BK_LT  = 3'd2,
        BK_NEZ = 3'd3,
        BK_GEZ = 3'd4
    } br_kind_e;

    localparam int INSTR_BYTES = 4;
    localparam int WORD_SHIFT  = 2;
endpackage

// File: rtl/pcu_branch_cond.sv
module pcu_branch_cond #(
    parameter int XLEN = 32
) (
    input  logic            br_en,
    input  logic [2:0]      br_kind,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            take
);
    import pcu_pkg::*;

    logic cond;
    logic eq_w, lt_w, zero_w, neg_w;

    always_comb begin
        eq_w   = (rs_val == rt_val);
        lt_w   = ($signed(rs_val) < $signed(rt_val));
        zero_w = (rs_val == '0);
        neg_w  = rs_val[XLEN-1];
        case (br_kind)
            BK_EQ:   cond = eq_w;
            BK_NE:   cond = !eq_w;
            BK_LT:   cond = lt_w;
            BK_NEZ:  cond = !zero_w;
            BK_GEZ:  cond = !neg_w;
            default: cond = 1'b0;
        endcase
        take = br_en & cond;
    end
endmodule

// File: rtl/pcu_target_gen.sv
module pcu_target_gen #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int JT_W  = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  pc_plus4,
    input  logic [IMM_W-1:0] imm,
    input  logic [JT_W-1:0]  jtarget,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jmp_tgt
);
    import pcu_pkg::*;

    localparam int SEXT_W   = XLEN - IMM_W - WORD_SHIFT;
    localparam int REGION_W = XLEN - JT_W - WORD_SHIFT;

    logic [XLEN-1:0] offset;

    always_comb begin
        offset  = {{SEXT_W{imm[IMM_W-1]}}, imm, {WORD_SHIFT{1'b0}}};
        br_tgt  = pc_plus4 + offset;
        jmp_tgt = {pc[XLEN-1 -: REGION_W], jtarget, {WORD_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int JT_W  = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_en,
    input  logic [2:0]       br_kind,
    input  logic             jmp,
    input  logic             jreg,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [IMM_W-1:0] imm,
    input  logic [JT_W-1:0]  jtarget,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  pc_plus4
);
    import pcu_pkg::*;

    localparam int SEXT_W   = XLEN - IMM_W - WORD_SHIFT;
    localparam int REGION_W = XLEN - JT_W - WORD_SHIFT;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } seq_state_t;

    seq_state_t state_d, state_q;
    logic            take_w;
    logic [XLEN-1:0] br_tgt_w, jmp_tgt_w, inc_w;

    assign inc_w = state_q.pc + XLEN'(INSTR_BYTES);

    pcu_branch_cond #(.XLEN(XLEN)) u_cond (
        .br_en   (br_en),
        .br_kind (br_kind),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .take    (take_w)
    );

    pcu_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JT_W(JT_W)) u_tgt (
        .pc       (state_q.pc),
        .pc_plus4 (inc_w),
        .imm      (imm),
        .jtarget  (jtarget),
        .br_tgt   (br_tgt_w),
        .jmp_tgt  (jmp_tgt_w)
    );

    always_comb begin
        state_d = state_q;
        if (rst)          state_d.pc = '0;
        else if (jreg)    state_d.pc = rs_val;
        else if (jmp)     state_d.pc = jmp_tgt_w;
        else if (take_w)  state_d.pc = br_tgt_w;
        else              state_d.pc = inc_w;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc       = state_q.pc;
    assign pc_plus4 = inc_w;

    // R12
    jreg_load_chk: assert property (@(posedge clk) disable iff (rst)
        jreg |=> (pc == $past(rs_val)));

    // R11
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (jmp && !jreg) |=> (pc == {$past(pc[XLEN-1 -: REGION_W]), $past(jtarget), 2'b00}));

    // R4
    branch_target_chk: assert property (@(posedge clk) disable iff (rst)
        (take_w && !jmp && !jreg) |=>
        (pc == $past(pc) + XLEN'(4) + {{SEXT_W{$past(imm[IMM_W-1])}}, $past(imm), 2'b00}));

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!br_en && !jmp && !jreg) |=> (pc == $past(pc) + XLEN'(4)));

    // R10
    no_branch_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !br_en |-> !take_w);
endmodule

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_en = 1'b0;
    logic [2:0]  br_kind = 3'd0;
    logic        jmp = 1'b0;
    logic        jreg = 1'b0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm = '0;
    logic [25:0] jtarget = '0;
    logic [31:0] pc, pc_plus4;

    int errors = 0;
    int checks = 0;
    logic [31:0] cur_pc = '0;
    bit finished = 0;

    always #2 clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst(rst), .br_en(br_en), .br_kind(br_kind), .jmp(jmp),
        .jreg(jreg), .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
        .jtarget(jtarget), .pc(pc), .pc_plus4(pc_plus4)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_next(logic be, logic [2:0] k, logic j,
            logic jr, logic [31:0] a, logic [31:0] b, logic [15:0] im,
            logic [25:0] jt, logic [31:0] p);
        logic c;
        case (k)
            3'd0: c = (a == b);
            3'd1: c = (a != b);
            3'd2: c = ($signed(a) < $signed(b));
            3'd3: c = (a != 0);
            3'd4: c = ($signed(a) >= 0);
            default: c = 1'b0;
        endcase
        if (jr) return a;
        if (j) return {p[31:28], jt, 2'b00};
        if (be && c) return p + 32'd4 + {{14{im[15]}}, im, 2'b00};
        return p + 32'd4;
    endfunction

    task automatic step(string tag, logic be, logic [2:0] k, logic j, logic jr,
            logic [31:0] a, logic [31:0] b, logic [15:0] im, logic [25:0] jt);
        logic [31:0] exp;
        exp = ref_next(be, k, j, jr, a, b, im, jt, cur_pc);
        br_en = be; br_kind = k; jmp = j; jreg = jr;
        rs_val = a; rt_val = b; imm = im; jtarget = jt;
        @(posedge clk); #1;
        check(tag, pc, exp);
        check("R3 link", pc_plus4, exp + 32'd4);
        cur_pc = exp;
        br_en = 0; jmp = 0; jreg = 0;
    endtask

    task automatic goto(logic [31:0] a);
        step("R12 jreg", 0, 0, 0, 1, a, 0, 0, 0);
    endtask

    task automatic t_reset;
        rst = 1;
        @(posedge clk); #1;
        rst = 0;
        check("R1 pc", pc, 32'd0);
        check("R1 pc_plus4", pc_plus4, 32'd4);
        cur_pc = 0;
    endtask

    task automatic t_sequential;
        for (int i = 0; i < 3; i++) step("R2 seq", 0, 0, 0, 0, 32'h55, 32'h55, 16'h10, 26'h7);
    endtask

    task automatic t_eq;
        goto(32'h0000_1000);
        step("R5 eq taken", 1, 3'd0, 0, 0, 32'd9, 32'd9, 16'h0004, 0);
        step("R5 eq not", 1, 3'd0, 0, 0, 32'd9, 32'd8, 16'h0004, 0);
        step("R4 eq back", 1, 3'd0, 0, 0, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 16'hFFFC, 0);
    endtask

    task automatic t_ne;
        step("R6 ne taken", 1, 3'd1, 0, 0, 32'd1, 32'd2, 16'h0020, 0);
        step("R6 ne not", 1, 3'd1, 0, 0, 32'd7, 32'd7, 16'h0020, 0);
        step("R4 ne back", 1, 3'd1, 0, 0, 32'd0, 32'd3, 16'hFFF0, 0);
    endtask

    task automatic t_lt;
        step("R7 lt neg<pos", 1, 3'd2, 0, 0, 32'hFFFF_FFFB, 32'd3, 16'h0008, 0);
        step("R7 lt pos<neg", 1, 3'd2, 0, 0, 32'd3, 32'hFFFF_FFFB, 16'h0008, 0);
        step("R7 lt equal", 1, 3'd2, 0, 0, 32'd5, 32'd5, 16'h0008, 0);
        step("R7 lt neg<neg", 1, 3'd2, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 16'hFFF8, 0);
    endtask

    task automatic t_nez;
        step("R8 nez taken", 1, 3'd3, 0, 0, 32'hFFFF_FFFF, 32'd0, 16'h0002, 0);
        step("R8 nez zero", 1, 3'd3, 0, 0, 32'd0, 32'd9, 16'h0002, 0);
    endtask

    task automatic t_gez;
        step("R9 gez neg", 1, 3'd4, 0, 0, 32'hFFFF_FFFF, 32'd0, 16'h0006, 0);
        step("R9 gez zero", 1, 3'd4, 0, 0, 32'd0, 32'd0, 16'h0006, 0);
        step("R9 gez pos", 1, 3'd4, 0, 0, 32'd7, 32'd0, 16'hFFFE, 0);
    endtask

    task automatic t_disabled;
        step("R10 br_en low", 0, 3'd0, 0, 0, 32'd4, 32'd4, 16'h0100, 0);
        step("R10 kind5", 1, 3'd5, 0, 0, 32'd4, 32'd4, 16'h0100, 0);
        step("R10 kind7", 1, 3'd7, 0, 0, 32'd0, 32'd1, 16'h0100, 0);
    endtask

    task automatic t_jump;
        goto(32'hA000_0010);
        step("R11 jump", 0, 0, 1, 0, 0, 0, 0, 26'h123_4567);
        check("R11 value", cur_pc, 32'hA48D_159C);
    endtask

    task automatic t_priority;
        step("R13 jreg wins", 1, 3'd0, 1, 1, 32'h0000_4000, 32'h0000_4000, 16'h0010, 26'h3F);
        check("R13 value", pc, 32'h0000_4000);
        step("R13 jmp over br", 1, 3'd0, 1, 0, 32'd1, 32'd1, 16'h0010, 26'h40);
        check("R13 value2", pc, 32'h0000_0100);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        rst = 0;
        check("R1 pc", pc, 32'd0);
        check("R1 pc_plus4", pc_plus4, 32'd4);
        cur_pc = 0;
        t_sequential();
        t_eq();
        t_ne();
        t_lt();
        t_nez();
        t_gez();
        t_disabled();
        t_jump();
        t_priority();
        t_reset();
        t_sequential();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule